// File: doc/BRIEF.md
# Dual-Slot Glitchless CPU Clock Switch

This block selects the clock that drives a CPU clock domain. A 32-bit control register holds two complete configurations, called slots. Each slot has a source pre-select (crystal reference, fixed PLL divided by two, or fixed PLL divided by three), a post-select that either passes that source straight through or sends it through a counting divider, and the divider value itself. A final selector chooses between the main PLL output and the dynamic path fed by the active slot. An enable bit gates the result.

To change the dynamic clock, software writes new settings into the idle slot and flips the slot-select bit in the same write. The block then runs a handover. It closes the gate of the old slot in a cycle where that slot's clock is low. It waits a fixed number of synchronizer cycles and then opens the gate of the new slot. A busy flag reads as one from the cycle after the request until the new gate is open. The live path is never changed in mid-flight.

All clocks are modelled as single-cycle enable pulses on a fast reference clock. The output is a registered pulse train with the same meaning.

Top module: `cpu_clk_switch`

## Requirements
- R1: After reset the register reads zero, busy reads zero, slot 0 is the active slot, and `cpuTick` stays low.
- R2: Bit 26 enables the output. While it is 0, `cpuTick` never pulses.
- R3: Bit 11 picks the final source. 1 forwards every `pllTick` pulse, and 0 forwards the dynamic path. The output is registered, so each pulse appears one cycle after its source.
- R4: Pre-select code 0 picks `xtalTick`, code 1 picks `fixDiv2Tick` and code 2 picks `fixDiv3Tick`. Code 3 is reserved and behaves exactly like code 0.
- R5: With the post-select bit 0, the slot passes its pre-selected pulses unchanged. With it 1, the slot emits one pulse per (divider field + 1) source pulses.
- R6: Slot 0 takes its pre-select from bits [1:0], its post-select from bit 2 and its divider from bits [9:4]. Slot 1 uses bits [17:16], bit 18 and bits [25:20].
- R7: A write that makes bit 10 differ from the active slot requests a handover. Busy (read-only bit 28) reads 1 from the next cycle onward.
- R8: During a handover, the old slot's gate closes in the first cycle its pulse is low. After SYNC_CYC further cycles the new gate opens, and busy clears in that same edge. The two gates are never open together. With the defaults, busy is visible for 4 or 5 cycles.
- R9: While busy, a write leaves bit 10 and the fields of the slot that bit 10 selects unchanged. All other bits take the written value.
- R10: Bit 28 cannot be written. It reads 0 whenever no handover is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Register write value |
| rdData | output | 32 | Register readback with busy in bit 28 |
| xtalTick | input | 1 | Crystal reference pulse |
| fixDiv2Tick | input | 1 | Fixed PLL /2 pulse |
| fixDiv3Tick | input | 1 | Fixed PLL /3 pulse |
| pllTick | input | 1 | Main PLL pulse |
| cpuTick | output | 1 | Selected CPU clock pulse |

## Verification
The assertions assume that the source pulse inputs never stay high for two cycles in a row, so that a low phase always arrives. They also assume that software issues a new request only after busy has cleared. The bench meets both conditions. It drives the crystal, /2 and /3 sources with pulse periods of 5, 2 and 3 cycles. It polls busy until it reads zero before each new request, except in the one directed case that deliberately writes during a handover to show that the protected fields hold. Random slot settings keep the divider field small, so that period measurements stay short.

// File: rtl/cksw_pkg.sv
package cksw_pkg;
  localparam int DIV_W = 6;
  localparam int NUM_SLOTS = 2;
  localparam int BIT_BUSY = 28;
  localparam int BIT_EN = 26;
  localparam int BIT_FINAL = 11;
  localparam int BIT_SLOT = 10;
  localparam int SLOT1_BASE = 16;
  localparam logic [31:0] SLOT_MASK0 = 32'h0000_03F7;
  localparam logic [31:0] SLOT_MASK1 = SLOT_MASK0 << SLOT1_BASE;

  typedef struct packed {
    logic [1:0]       pre;
    logic             post;
    logic [DIV_W-1:0] div;
  } slot_cfg_t;

  typedef struct packed {
    logic closeVld;
    logic closeIdx;
    logic openVld;
    logic openIdx;
  } gate_cmd_t;

  typedef enum logic [1:0] {ST_IDLE, ST_DRAIN, ST_SYNC} hand_state_t;
endpackage

// File: rtl/cksw_ctrl.sv
module cksw_ctrl
  import cksw_pkg::*;
#(
  parameter int SYNC_CYC = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [31:0]     wrData,
  input  logic [1:0]      slotRaw,
  output logic [31:0]     rdData,
  output slot_cfg_t       slotCfg [NUM_SLOTS],
  output logic            finalPll,
  output logic            outEn,
  output gate_cmd_t       gateCmd
);
  localparam int CNT_W = (SYNC_CYC > 1) ? $clog2(SYNC_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SYNC_CYC - 1);

  logic [31:0] ctrlQ;
  logic [31:0] protectMask;
  logic        activeSel;
  logic        busy;
  logic [CNT_W-1:0] syncCnt;
  hand_state_t state;

  assign busy = (state != ST_IDLE) || (ctrlQ[BIT_SLOT] != activeSel);
  assign rdData = ctrlQ | (32'(busy) << BIT_BUSY);
  assign finalPll = ctrlQ[BIT_FINAL];
  assign outEn = ctrlQ[BIT_EN];

  genvar s;
  generate
    for (s = 0; s < NUM_SLOTS; s++) begin : g_cfg
      localparam int BASE = s * SLOT1_BASE;
      assign slotCfg[s].pre  = ctrlQ[BASE+1:BASE];
      assign slotCfg[s].post = ctrlQ[BASE+2];
      assign slotCfg[s].div  = ctrlQ[BASE+4+DIV_W-1:BASE+4];
    end
  endgenerate

  always_comb begin
    protectMask = '0;
    if (busy) begin
      protectMask = (32'd1 << BIT_SLOT) | (ctrlQ[BIT_SLOT] ? SLOT_MASK1 : SLOT_MASK0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (wrEn) begin
      ctrlQ <= ((wrData & ~protectMask) | (ctrlQ & protectMask)) & ~(32'd1 << BIT_BUSY);
    end
  end

  always_comb begin
    gateCmd = '0;
    if (state == ST_DRAIN && !slotRaw[activeSel]) begin
      gateCmd.closeVld = 1'b1;
      gateCmd.closeIdx = activeSel;
    end
    if (state == ST_SYNC && syncCnt == CNT_LAST) begin
      gateCmd.openVld = 1'b1;
      gateCmd.openIdx = ctrlQ[BIT_SLOT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      activeSel <= 1'b0;
      syncCnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (ctrlQ[BIT_SLOT] != activeSel) state <= ST_DRAIN;
        end
        ST_DRAIN: begin
          if (gateCmd.closeVld) begin
            state   <= ST_SYNC;
            syncCnt <= '0;
          end
        end
        ST_SYNC: begin
          if (gateCmd.openVld) begin
            state     <= ST_IDLE;
            activeSel <= gateCmd.openIdx;
          end else begin
            syncCnt <= syncCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: a fresh request shows busy on the next cycle
  p_busy_on_req_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && wrEn && (wrData[BIT_SLOT] != ctrlQ[BIT_SLOT])) |=> busy);
  // R9: slot-select cannot move while busy
  p_sel_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEn) |=> $stable(ctrlQ[BIT_SLOT]));
  // R8: busy only clears out of the synchronizer wait
  p_busy_fall_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(state) == ST_SYNC));
  // R10: the stored busy bit is never set
  p_busy_ro_r10: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ[BIT_BUSY]);
endmodule

// File: rtl/cksw_datapath.sv
module cksw_datapath
  import cksw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       xtalTick,
  input  logic       fixDiv2Tick,
  input  logic       fixDiv3Tick,
  input  logic       pllTick,
  input  slot_cfg_t  slotCfg [NUM_SLOTS],
  input  logic       finalPll,
  input  logic       outEn,
  input  gate_cmd_t  gateCmd,
  output logic [1:0] slotRaw,
  output logic       cpuTick
);
  logic [NUM_SLOTS-1:0] gateOpen;
  logic [NUM_SLOTS-1:0] gated;
  logic dynTick;

  genvar s;
  generate
    for (s = 0; s < NUM_SLOTS; s++) begin : g_slot
      logic srcTick;
      logic [DIV_W-1:0] divCnt;
      logic divHit;

      always_comb begin
        case (slotCfg[s].pre)
          2'd1:    srcTick = fixDiv2Tick;
          2'd2:    srcTick = fixDiv3Tick;
          default: srcTick = xtalTick;
        endcase
      end

      assign divHit = (divCnt >= slotCfg[s].div);

      always_ff @(posedge clk) begin
        if (!rstN || !gateOpen[s]) begin
          divCnt <= '0;
        end else if (srcTick && slotCfg[s].post) begin
          divCnt <= divHit ? '0 : divCnt + 1'b1;
        end
      end

      assign slotRaw[s] = slotCfg[s].post ? (srcTick && divHit) : srcTick;
      assign gated[s]   = slotRaw[s] && gateOpen[s];
    end
  endgenerate

  assign dynTick = |gated;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gateOpen <= 2'b01;
    end else begin
      if (gateCmd.closeVld) gateOpen[gateCmd.closeIdx] <= 1'b0;
      if (gateCmd.openVld)  gateOpen[gateCmd.openIdx]  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) cpuTick <= 1'b0;
    else       cpuTick <= outEn && (finalPll ? pllTick : dynTick);
  end

  // R8: the two slot gates are never open together
  p_gate_onehot_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(gateOpen));
  // R8: a new gate opens only after the old one is shut
  p_open_after_close_r8: assert property (@(posedge clk) disable iff (!rstN)
    gateCmd.openVld |-> (gateOpen == '0));
  // R2: no output pulse without the enable
  p_en_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    cpuTick |-> $past(outEn));
endmodule

// File: rtl/cpu_clk_switch.sv
module cpu_clk_switch
  import cksw_pkg::*;
#(
  parameter int SYNC_CYC = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  input  logic        xtalTick,
  input  logic        fixDiv2Tick,
  input  logic        fixDiv3Tick,
  input  logic        pllTick,
  output logic        cpuTick
);
  slot_cfg_t slotCfg [NUM_SLOTS];
  gate_cmd_t gateCmd;
  logic [1:0] slotRaw;
  logic finalPll;
  logic outEn;

  cksw_ctrl #(.SYNC_CYC(SYNC_CYC)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .slotRaw(slotRaw), .rdData(rdData), .slotCfg(slotCfg),
    .finalPll(finalPll), .outEn(outEn), .gateCmd(gateCmd)
  );

  cksw_datapath i_dp (
    .clk(clk), .rstN(rstN), .xtalTick(xtalTick), .fixDiv2Tick(fixDiv2Tick),
    .fixDiv3Tick(fixDiv3Tick), .pllTick(pllTick), .slotCfg(slotCfg),
    .finalPll(finalPll), .outEn(outEn), .gateCmd(gateCmd),
    .slotRaw(slotRaw), .cpuTick(cpuTick)
  );
endmodule

// File: tb/test_cpu_clk_switch.sv
module test_cpu_clk_switch;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic xtalTick = 1'b0, fixDiv2Tick = 1'b0, fixDiv3Tick = 1'b0, pllTick = 1'b0;
  logic cpuTick;
  int checks = 0;
  int errors = 0;
  int unsigned curReg = 0;
  int unsigned seed = 32'h1234_5678;

  always #10 clk = ~clk;

  cpu_clk_switch i_cpu_clk_switch (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .xtalTick(xtalTick), .fixDiv2Tick(fixDiv2Tick), .fixDiv3Tick(fixDiv3Tick),
    .pllTick(pllTick), .cpuTick(cpuTick)
  );

  initial begin
    int unsigned n;
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      xtalTick    = (n % 5) == 0;
      fixDiv2Tick = (n % 2) == 0;
      fixDiv3Tick = (n % 3) == 0;
      pllTick     = 1'b1;
    end
  end

  function automatic int unsigned srcPeriod(int unsigned pre);
    case (pre)
      1: return 2;
      2: return 3;
      default: return 5;
    endcase
  endfunction

  function automatic int unsigned expPeriod(int unsigned pre, int unsigned post, int unsigned dv);
    return post != 0 ? srcPeriod(pre) * (dv + 1) : srcPeriod(pre);
  endfunction

  function automatic logic [31:0] slotBits(int unsigned idx, int unsigned pre,
                                           int unsigned post, int unsigned dv);
    logic [31:0] v;
    v = 32'((pre & 3) | ((post & 1) << 2) | ((dv & 63) << 4));
    return idx != 0 ? (v << 16) : v;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic [31:0] v);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic countBusy(output int unsigned n);
    n = 0;
    while (rdData[28] && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic measure(output int unsigned per);
    int unsigned k;
    per = 0;
    for (int rep = 0; rep < 2; rep++) begin
      k = 0;
      @(negedge clk);
      while (!cpuTick && k < 400) begin k++; @(negedge clk); end
      k = 0;
      @(negedge clk);
      k = 1;
      while (!cpuTick && k < 400) begin k++; @(negedge clk); end
      per = k;
    end
  endtask

  task automatic countTicks(int unsigned cyc, output int unsigned n);
    n = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (cpuTick) n++;
    end
  endtask

  task automatic doSwitch(string req, int unsigned pre, int unsigned post, int unsigned dv);
    int unsigned tgt, nb, per;
    logic [31:0] v;
    tgt = curReg[10] ? 0 : 1;
    v = curReg & ~(tgt != 0 ? 32'h03F7_0000 : 32'h0000_03F7) & ~32'h0000_0400;
    v = v | slotBits(tgt, pre, post, dv) | (32'(tgt) << 10);
    curReg = v;
    regWrite(v);
    check({req, " R7 busy after request"}, 32'(rdData[28]), 32'd1);
    countBusy(nb);
    checks++;
    if (nb < 4 || nb > 5) begin
      errors++;
      $display("FAIL R8 busy cycles actual=%0d expected=4..5", nb);
    end
    check({req, " R10 readback after handover"}, rdData, v);
    measure(per);
    check({req, " R4 R5 R6 period"}, per, expPeriod(pre, post, dv));
  endtask

  initial begin
    int unsigned n, per;
    logic [31:0] v, exp;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset register", rdData, 32'h0);
    countTicks(30, n);
    check("R1 no ticks after reset", n, 0);

    // slot 0 live, fixed /2 undivided
    curReg = (1 << 26) | slotBits(0, 1, 0, 0);
    regWrite(curReg);
    check("R7 no busy without toggle", 32'(rdData[28]), 32'd0);
    measure(per);
    check("R4 R5 slot0 fix/2 period", per, 2);

    doSwitch("R6 slot1 fix/3 div4", 2, 1, 3);
    doSwitch("R4 reserved code 3", 3, 0, 0);
    doSwitch("R4 xtal div2", 0, 1, 1);
    doSwitch("R5 post0 ignores div", 1, 0, 5);

    for (int it = 0; it < 8; it++) begin
      int unsigned pre, post, dv;
      pre  = $urandom(seed) % 4;
      seed = seed + 17;
      post = $urandom() % 2;
      dv   = $urandom() % 8;
      doSwitch("R5 random", pre, post, dv);
    end

    // R9: write while busy
    begin
      int unsigned tgt, nb;
      logic [31:0] req, mid;
      tgt = curReg[10] ? 0 : 1;
      req = (curReg & ~(tgt != 0 ? 32'h03F7_0000 : 32'h0000_03F7) & ~32'h400)
            | slotBits(tgt, 1, 1, 2) | (32'(tgt) << 10);
      regWrite(req);
      mid = (req ^ 32'h03F7_03F7 ^ 32'h400) | (1 << 26);
      regWrite(mid);
      countBusy(nb);
      exp = (mid & ~(tgt != 0 ? 32'h03F7_0000 : 32'h0000_03F7) & ~32'h400)
            | (req & ((tgt != 0 ? 32'h03F7_0000 : 32'h0000_03F7) | 32'h400));
      check("R9 protected fields held", rdData, exp);
      curReg = exp;
      measure(per);
      check("R9 new slot period", per, expPeriod(1, 1, 2));
    end

    // R10: busy bit not writable
    regWrite(curReg | (1 << 28));
    check("R10 busy write ignored", rdData, curReg);

    // R3: final selects PLL
    curReg = curReg | (1 << 11);
    regWrite(curReg);
    measure(per);
    check("R3 pll period", per, 1);
    countTicks(20, n);
    check("R3 pll every cycle", n, 20);

    // R2: enable off
    curReg = curReg & ~(32'd1 << 26);
    regWrite(curReg);
    @(negedge clk);
    countTicks(60, n);
    check("R2 disabled no ticks", n, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule